// File: doc/BRIEF.md
# Iterative Non-Restoring Divider with Exposed Step Primitive

This block provides the one-bit division step of a 32-bit processor and a small sequencer that runs the step back to back to produce an unsigned quotient. A step takes a partial remainder, a divisor and three status flags: the quotient-polarity flag Q, the divisor-sign flag M and the carry-in flag T. It shifts the remainder left with T entering at the bottom and either subtracts or adds the divisor. It then produces a new Q and a new T, and the new T is the quotient bit.

The step is reachable on its own through a purely combinational port group, so a datapath can issue it one instruction at a time. The sequencer clears the flags and a remainder register and keeps the dividend in a second register. On every clock it runs one step and rotates that register left, taking in the new quotient bit and feeding the next dividend bit in as T. After `W` steps the second register holds the quotient. The parameter `STEP_IMPL` selects how the carry or borrow is formed.

Top module: `divstep_unit`

## Requirements
- R1: Step datapath. Let `sh = {rem[W-2:0], t}`. The step output is `sh - div` (mod 2^W) when the incoming Q equals M, and `sh + div` (mod 2^W) otherwise.
- R2: Step Q update. Let `msb` be rem[W-1], the bit shifted out, and `cy` the borrow of the subtraction or the carry of the addition. The new Q is `msb XOR cy XOR M`.
- R3: Step T update. The new T is 1 exactly when the new Q equals M, which is the same as `NOT(msb XOR cy)`.
- R4: After reset, busy_o, done_o and quotient_o are all 0.
- R5: A start_i sampled high while busy_o is low sets busy_o in the next cycle. busy_o then stays high for exactly W cycles. done_o is high for a single cycle, the cycle in which busy_o falls.
- R6: For a divisor other than zero, the quotient_o presented with done_o equals floor(dividend / divisor), both taken unsigned.
- R7: A divisor of zero yields a quotient of all ones.
- R8: start_i while busy_o is high is ignored. The run in progress keeps its operands and its timing.
- R9: quotient_o changes only in a cycle where done_o is high, and otherwise holds the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a division, taken only when idle |
| dividend_i | input | W | Unsigned dividend, sampled with an accepted start |
| divisor_i | input | W | Unsigned divisor, sampled with an accepted start |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quotient_o | output | W | Quotient of the last completed division |
| stp_rem_i | input | W | Step: partial remainder in |
| stp_div_i | input | W | Step: divisor |
| stp_q_i | input | 1 | Step: Q flag in |
| stp_m_i | input | 1 | Step: M flag |
| stp_t_i | input | 1 | Step: T flag in |
| stp_rem_o | output | W | Step: partial remainder out |
| stp_q_o | output | 1 | Step: Q flag out |
| stp_t_o | output | 1 | Step: T flag out (quotient bit) |

## Verification
A 4-bit instance drives the step port through every combination of remainder, divisor and the three flags. This separates the four add/subtract and Q-polarity cases, and also catches a swapped carry sense in any one of them. The same instance divides every pair of 4-bit operands, including a zero divisor and a dividend smaller than the divisor, and checks each quotient together with the completion latency. A 32-bit instance, using the other carry implementation, covers extreme operands and a start issued in the middle of a run. It also covers a restart in the completion cycle and holding of the result while the inputs wander.

// File: rtl/divstep_pkg.sv
package divstep_pkg;

   typedef enum int {
      STEP_CMP  = 0,
      STEP_WIDE = 1
   } step_impl_e;

   // Q polarity table of one step, indexed by old Q, M and the shifted-out bit
   function automatic logic next_q(input logic old_q, input logic m,
                                   input logic msb, input logic cy);
      logic r;
      unique case ({old_q, m})
         2'b00:   r = msb ? ~cy :  cy;
         2'b01:   r = msb ?  cy : ~cy;
         2'b10:   r = msb ? ~cy :  cy;
         default: r = msb ?  cy : ~cy;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/divstep_core.sv
module divstep_core
   import divstep_pkg::*;
#(
   parameter int W         = 32,
   parameter int STEP_IMPL = STEP_CMP
) (
   input  logic [W-1:0] rem_i,
   input  logic [W-1:0] div_i,
   input  logic         q_i,
   input  logic         m_i,
   input  logic         t_i,
   output logic [W-1:0] rem_o,
   output logic         q_o,
   output logic         t_o
);

   logic [W-1:0] shifted;
   logic         out_bit;
   logic         do_sub;
   logic         cy;

   assign shifted = {rem_i[W-2:0], t_i};
   assign out_bit = rem_i[W-1];
   assign do_sub  = (q_i == m_i);

   generate
      if (STEP_IMPL == STEP_WIDE) begin : g_wide
         logic [W:0] ext;
         always_comb begin
            if (do_sub) ext = {1'b0, shifted} - {1'b0, div_i};
            else        ext = {1'b0, shifted} + {1'b0, div_i};
         end
         assign rem_o = ext[W-1:0];
         assign cy    = ext[W];
      end else begin : g_cmp
         logic [W-1:0] res;
         always_comb begin
            if (do_sub) res = shifted - div_i;
            else        res = shifted + div_i;
         end
         assign rem_o = res;
         assign cy    = do_sub ? (res > shifted) : (res < shifted);
      end
   endgenerate

   assign q_o = next_q(q_i, m_i, out_bit, cy);
   assign t_o = (q_o == m_i);

endmodule

// File: rtl/divstep_seq.sv
module divstep_seq
   import divstep_pkg::*;
#(
   parameter int W         = 32,
   parameter int STEP_IMPL = STEP_CMP
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [W-1:0] dividend_i,
   input  logic [W-1:0] divisor_i,
   output logic         busy_o,
   output logic         done_o,
   output logic [W-1:0] quotient_o
);

   localparam int CW = (W > 2) ? $clog2(W) : 1;
   localparam logic [CW-1:0] LAST = CW'(W - 1);
   localparam logic M_UNSIGNED = 1'b0;

   logic [W-1:0]  rem_r;
   logic [W-1:0]  acc_r;
   logic [W-1:0]  dvs_r;
   logic          q_r;
   logic [CW-1:0] cnt_r;

   logic [W-1:0]  rem_nx;
   logic          q_nx;
   logic          t_nx;
   logic [W-1:0]  acc_nx;

   divstep_core #(.W(W), .STEP_IMPL(STEP_IMPL)) u_core (
      .rem_i (rem_r),
      .div_i (dvs_r),
      .q_i   (q_r),
      .m_i   (M_UNSIGNED),
      .t_i   (acc_r[W-1]),
      .rem_o (rem_nx),
      .q_o   (q_nx),
      .t_o   (t_nx)
   );

   assign acc_nx = {acc_r[W-2:0], t_nx};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_r      <= '0;
         acc_r      <= '0;
         dvs_r      <= '0;
         q_r        <= 1'b0;
         cnt_r      <= '0;
         busy_o     <= 1'b0;
         done_o     <= 1'b0;
         quotient_o <= '0;
      end else begin
         done_o <= 1'b0;
         if (busy_o) begin
            rem_r <= rem_nx;
            q_r   <= q_nx;
            acc_r <= acc_nx;
            cnt_r <= cnt_r + 1'b1;
            if (cnt_r == LAST) begin
               busy_o     <= 1'b0;
               done_o     <= 1'b1;
               quotient_o <= acc_nx;
            end
         end else if (start_i) begin
            rem_r  <= '0;
            acc_r  <= dividend_i;
            dvs_r  <= divisor_i;
            q_r    <= 1'b0;
            cnt_r  <= '0;
            busy_o <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/divstep_unit.sv
module divstep_unit
   import divstep_pkg::*;
#(
   parameter int W         = 32,
   parameter int STEP_IMPL = STEP_CMP
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [W-1:0] dividend_i,
   input  logic [W-1:0] divisor_i,
   output logic         busy_o,
   output logic         done_o,
   output logic [W-1:0] quotient_o,
   input  logic [W-1:0] stp_rem_i,
   input  logic [W-1:0] stp_div_i,
   input  logic         stp_q_i,
   input  logic         stp_m_i,
   input  logic         stp_t_i,
   output logic [W-1:0] stp_rem_o,
   output logic         stp_q_o,
   output logic         stp_t_o
);

   generate
      if (W < 2) begin : g_bad_width
         $error("divstep_unit: W must be at least 2");
      end
      if (STEP_IMPL != STEP_CMP && STEP_IMPL != STEP_WIDE) begin : g_bad_impl
         $error("divstep_unit: STEP_IMPL must be 0 or 1");
      end
   endgenerate

   divstep_core #(.W(W), .STEP_IMPL(STEP_IMPL)) u_step (
      .rem_i (stp_rem_i),
      .div_i (stp_div_i),
      .q_i   (stp_q_i),
      .m_i   (stp_m_i),
      .t_i   (stp_t_i),
      .rem_o (stp_rem_o),
      .q_o   (stp_q_o),
      .t_o   (stp_t_o)
   );

   divstep_seq #(.W(W), .STEP_IMPL(STEP_IMPL)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .dividend_i (dividend_i),
      .divisor_i  (divisor_i),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .quotient_o (quotient_o)
   );

endmodule

// File: rtl/divstep_unit_chk.sv
module divstep_unit_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start_i,
   input logic         busy_o,
   input logic         done_o,
   input logic [W-1:0] quotient_o,
   input logic [W-1:0] stp_rem_i,
   input logic [W-1:0] stp_div_i,
   input logic         stp_q_i,
   input logic         stp_m_i,
   input logic         stp_t_i,
   input logic [W-1:0] stp_rem_o,
   input logic         stp_q_o,
   input logic         stp_t_o
);

   localparam int RW = $clog2(W + 1) + 1;

   logic [W-1:0] sh;
   logic         sub;
   logic [W:0]   wide_sub;
   logic [W:0]   wide_add;
   logic         cy;
   logic [RW-1:0] run_len;

   assign sh       = {stp_rem_i[W-2:0], stp_t_i};
   assign sub      = (stp_q_i == stp_m_i);
   assign wide_sub = {1'b0, sh} - {1'b0, stp_div_i};
   assign wide_add = {1'b0, sh} + {1'b0, stp_div_i};
   assign cy       = sub ? wide_sub[W] : wide_add[W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run_len <= '0;
      else if (busy_o) run_len <= run_len + 1'b1;
      else             run_len <= '0;
   end

   AST_STEP_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      stp_rem_o == (sub ? wide_sub[W-1:0] : wide_add[W-1:0])); // R1
   AST_STEP_Q_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
      stp_q_o == (stp_rem_i[W-1] ^ cy ^ stp_m_i)); // R2
   AST_STEP_T_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      stp_t_o == ~(stp_rem_i[W-1] ^ cy)); // R3
   AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o); // R5
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R5
   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && run_len == RW'(W))); // R5
   AST_BUSY_ONLY_W: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (run_len < RW'(W))); // R8
   AST_QUOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |=> (!done_o -> $stable(quotient_o))); // R9

endmodule

bind divstep_unit divstep_unit_chk #(.W(W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .quotient_o (quotient_o),
   .stp_rem_i  (stp_rem_i),
   .stp_div_i  (stp_div_i),
   .stp_q_i    (stp_q_i),
   .stp_m_i    (stp_m_i),
   .stp_t_i    (stp_t_i),
   .stp_rem_o  (stp_rem_o),
   .stp_q_o    (stp_q_o),
   .stp_t_o    (stp_t_o)
);

// File: tb/divstep_unit_bench.sv
module divstep_unit_bench;

   localparam int NW = 4;
   localparam int WW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   int checks = 0;
   int fails  = 0;

   // narrow instance (compare-based carry)
   logic          n_start = 1'b0;
   logic [NW-1:0] n_a = '0, n_b = '0;
   logic          n_busy, n_done;
   logic [NW-1:0] n_quot;
   logic [NW-1:0] s_rem = '0, s_div = '0;
   logic          s_q = 1'b0, s_m = 1'b0, s_t = 1'b0;
   logic [NW-1:0] s_rem_o;
   logic          s_q_o, s_t_o;

   divstep_unit #(.W(NW), .STEP_IMPL(0)) u_divstep_unit (
      .clk(clk), .rst_n(rst_n), .start_i(n_start),
      .dividend_i(n_a), .divisor_i(n_b),
      .busy_o(n_busy), .done_o(n_done), .quotient_o(n_quot),
      .stp_rem_i(s_rem), .stp_div_i(s_div), .stp_q_i(s_q), .stp_m_i(s_m),
      .stp_t_i(s_t), .stp_rem_o(s_rem_o), .stp_q_o(s_q_o), .stp_t_o(s_t_o)
   );

   // wide instance (extended-adder carry)
   logic          w_start = 1'b0;
   logic [WW-1:0] w_a = '0, w_b = '0;
   logic          w_busy, w_done;
   logic [WW-1:0] w_quot;
   logic [WW-1:0] w_rem_o;
   logic          w_q_o, w_t_o;

   divstep_unit #(.W(WW), .STEP_IMPL(1)) u_divstep_unit_wide (
      .clk(clk), .rst_n(rst_n), .start_i(w_start),
      .dividend_i(w_a), .divisor_i(w_b),
      .busy_o(w_busy), .done_o(w_done), .quotient_o(w_quot),
      .stp_rem_i('0), .stp_div_i('0), .stp_q_i(1'b0), .stp_m_i(1'b0),
      .stp_t_i(1'b0), .stp_rem_o(w_rem_o), .stp_q_o(w_q_o), .stp_t_o(w_t_o)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // one narrow division; latency measured in falling edges after the start edge
   task automatic run_narrow(input int a, input int b);
      int cyc;
      logic [NW-1:0] exp;
      @(negedge clk);
      n_a = NW'(a); n_b = NW'(b); n_start = 1'b1;
      @(negedge clk);
      n_start = 1'b0;
      check("R5 busy after start", {63'd0, n_busy}, 64'd1);
      cyc = 1;
      while (!n_done && cyc < 100) begin @(negedge clk); cyc++; end
      check("R5 latency", 64'(cyc), 64'(NW + 1));
      exp = (b == 0) ? '1 : NW'(a / b);
      if (b == 0) check("R7 zero divisor", 64'(n_quot), 64'(exp));
      else        check("R6 quotient", 64'(n_quot), 64'(exp));
      @(negedge clk);
      check("R5 done single cycle", {63'd0, n_done}, 64'd0);
   endtask

   task automatic run_wide(input logic [WW-1:0] a, input logic [WW-1:0] b);
      int cyc;
      logic [WW-1:0] exp;
      @(negedge clk);
      w_a = a; w_b = b; w_start = 1'b1;
      @(negedge clk);
      w_start = 1'b0;
      cyc = 1;
      while (!w_done && cyc < 100) begin @(negedge clk); cyc++; end
      check("R5 latency wide", 64'(cyc), 64'(WW + 1));
      exp = (b == 0) ? '1 : a / b;
      if (b == 0) check("R7 zero divisor wide", 64'(w_quot), 64'(exp));
      else        check("R6 quotient wide", 64'(w_quot), 64'(exp));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin : main
      logic [WW-1:0] first_q;
      int cyc;
      repeat (3) @(negedge clk);
      // R4 reset state
      check("R4 busy", {63'd0, n_busy}, 64'd0);
      check("R4 done", {63'd0, n_done}, 64'd0);
      check("R4 quotient", 64'(n_quot), 64'd0);
      check("R4 quotient wide", 64'(w_quot), 64'd0);
      rst_n = 1'b1;

      // R1 R2 R3 exhaustive step sweep
      for (int r = 0; r < (1 << NW); r++)
         for (int d = 0; d < (1 << NW); d++)
            for (int f = 0; f < 8; f++) begin
               int sh, res, msb, cy, qv, mv, tv;
               @(negedge clk);
               s_rem = NW'(r); s_div = NW'(d);
               qv = f & 1; mv = (f >> 1) & 1; tv = (f >> 2) & 1;
               s_q = qv[0]; s_m = mv[0]; s_t = tv[0];
               #1;
               sh  = ((r << 1) | tv) % (1 << NW);
               msb = (r >> (NW - 1)) & 1;
               if (qv == mv) begin res = sh - d; cy = (sh < d) ? 1 : 0; end
               else          begin res = sh + d; cy = (sh + d >= (1 << NW)) ? 1 : 0; end
               res = res & ((1 << NW) - 1);
               check("R1 step remainder", 64'(s_rem_o), 64'(res));
               check("R2 step Q", {63'd0, s_q_o}, 64'(msb ^ cy ^ mv));
               check("R3 step T", {63'd0, s_t_o}, 64'(1 - (msb ^ cy)));
            end

      // R6 R7 exhaustive narrow divisions
      for (int a = 0; a < (1 << NW); a++)
         for (int b = 0; b < (1 << NW); b++)
            run_narrow(a, b);

      // wide corner cases
      run_wide(32'hFFFF_FFFF, 32'd1);
      run_wide(32'hFFFF_FFFF, 32'hFFFF_FFFF);
      run_wide(32'd100, 32'd7);
      run_wide(32'd7, 32'd100);
      run_wide(32'h8000_0000, 32'd3);
      run_wide(32'hDEAD_BEEF, 32'd0);
      run_wide(32'h1234_5678, 32'h8000_0001);
      for (int k = 0; k < 8; k++) run_wide($urandom, $urandom >> (k * 4));

      // R8 start while busy ignored
      @(negedge clk);
      w_a = 32'd1000; w_b = 32'd9; w_start = 1'b1;
      @(negedge clk);
      w_start = 1'b0;
      repeat (4) @(negedge clk);
      w_a = 32'd5; w_b = 32'd1; w_start = 1'b1;
      @(negedge clk);
      w_start = 1'b0;
      cyc = 6;
      while (!w_done && cyc < 100) begin @(negedge clk); cyc++; end
      check("R8 timing kept", 64'(cyc), 64'(WW + 1));
      check("R8 operands kept", 64'(w_quot), 64'd111);
      first_q = w_quot;
      // restart in the completion cycle is accepted
      w_a = 32'd64; w_b = 32'd8; w_start = 1'b1;
      @(negedge clk);
      w_start = 1'b0;
      check("R5 restart on done", {63'd0, w_busy}, 64'd1);
      // R9 result held during the new run
      check("R9 hold during run", 64'(w_quot), 64'(first_q));
      cyc = 1;
      while (!w_done && cyc < 100) begin @(negedge clk); cyc++; end
      check("R6 restart result", 64'(w_quot), 64'd8);
      repeat (5) begin
         @(negedge clk);
         w_a = $urandom; w_b = $urandom;
      end
      check("R9 hold while idle", 64'(w_quot), 64'd8);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule